// File: doc/BRIEF.md
# Paired-Page Address Translator

This block turns a 32-bit virtual address into a physical address for instruction fetches and data accesses. It holds a small fully associative table. Each entry maps two neighbouring pages, called the even and the odd page, and keeps a frame number, a valid flag and a dirty flag for each of them. The size of the page is set per entry. A single virtual address bit, found at the entry's page-size position, picks which half of the pair is used.

Two kernel address windows are not mapped. An access to them skips the table and has its top three address bits removed. Any other address is looked up under the virtual page key and the current address-space identifier. The lookup gives either a physical address with a hit strobe or exactly one fault code. The fault codes cover a misaligned or privileged access, no matching entry, an invalid page and a store to a clean page.

Software fills the table one entry at a time through an indexed write port. The lookup path is combinational. An entry that is written on a clock edge takes part in lookups from the next cycle on.

Top module: `tlbx_translator`

## Requirements
- R1: After reset every entry is empty. A valid, aligned request to a mapped address (va[31:30] not equal to 2'b10) reports fault code 3 (refill, load) or 4 (refill, store) until an entry is written.
- R2: An access is misaligned when (req_size - 1) & req_vaddr[2:0] is nonzero. A misaligned access reports fault code 1 when req_write is 0 and code 2 when req_write is 1. This fault outranks every other fault, in every address window.
- R3: When va[31:29] = 3'b100 (lower unmapped window), a kernel-mode (req_kernel = 1) aligned access hits with paddr = {3'b000, va[28:0]}. A user-mode access reports fault code 1 or 2 (load or store).
- R4: When va[31:29] = 3'b101 (upper unmapped window), an aligned access hits with paddr = {3'b000, va[28:0]} in either processor mode.
- R5: The lookup key is va[31:11], with bits [1:0] forced to 0 unless req_small = 1. rsp_vpn always shows this key.
- R6: An entry matches when at least one of its halves is valid, its ASID equals req_asid, and its stored key equals the lookup key on every key bit at or above position (shift - 10). An entry with both halves invalid is empty. If several entries match, the lowest index wins.
- R7: An entry written with its global flag set matches whatever req_asid is.
- R8: A mapped, aligned access that matches no entry reports fault code 3 (load) or 4 (store).
- R9: va[shift] of the winning entry selects the half: 0 picks the even page and 1 picks the odd page. If the selected half is invalid, the block reports fault code 5 (load) or 6 (store).
- R10: A store (req_write = 1) to a valid half whose dirty flag is 0 reports fault code 7. A load from the same half hits.
- R11: On a mapped hit, paddr is {pfn, 12'b0} with every bit below the entry's shift replaced by the same bit of va. The shift must lie between MIN_SHIFT and MAX_SHIFT.
- R12: A write through the entry port takes effect on the clock edge. A lookup in the next cycle uses the new contents, including removing an entry by writing both halves invalid.
- R13: rsp_hit is 1 exactly when req_valid is 1 and the fault code is 0 (none). rsp_paddr is 0 whenever rsp_hit is 0. While req_valid is 0, the fault code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the entry write port |
| rst_n | input | 1 | Asynchronous active-low reset; empties all entries |
| req_valid | input | 1 | Request present |
| req_vaddr | input | 32 | Virtual address |
| req_size | input | SIZE_W | Access size in bytes (1, 2 or 4) |
| req_asid | input | ASID_W | Current address-space identifier |
| req_write | input | 1 | 1 for a store, 0 for a load or fetch |
| req_kernel | input | 1 | 1 when the processor is in kernel mode |
| req_small | input | 1 | Small-page mode; keeps key bits [1:0] |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | IDX_W | Entry index to write |
| wr_vpn | input | 21 | Stored page key |
| wr_asid | input | ASID_W | Stored address-space identifier |
| wr_global | input | 1 | Global flag: the ASID is not compared |
| wr_shift | input | 5 | Page-size shift (log2 of page bytes) |
| wr_pfn_even | input | 20 | Even page frame number (4 KiB units) |
| wr_valid_even | input | 1 | Even page valid |
| wr_dirty_even | input | 1 | Even page writable |
| wr_pfn_odd | input | 20 | Odd page frame number (4 KiB units) |
| wr_valid_odd | input | 1 | Odd page valid |
| wr_dirty_odd | input | 1 | Odd page writable |
| rsp_hit | output | 1 | Translation completed |
| rsp_paddr | output | 32 | Physical address (0 without a hit) |
| rsp_fault | output | 3 | 0 none, 1/2 address error load/store, 3/4 refill, 5/6 invalid, 7 modified |
| rsp_vpn | output | 21 | Lookup key formed from the request |

## Verification
The following are checked on every cycle: misalignment always wins as an address error, a user access to the lower window traps, the upper window always translates by stripping the top bits, the modified fault appears only for stores, at most one entry is granted, and the hit strobe agrees with the fault code and the idle state. A written entry's key is also checked one cycle after the write. Everything that depends on table contents can only be shown by the bench scenarios. This covers the half selection, the physical address for each page size, global entries, priority among duplicate entries, the key clearing for small-page mode, and removing entries by rewriting them.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
   localparam int VA_W      = 32;
   localparam int KEY_LSB   = 11;
   localparam int KEY_W     = VA_W - KEY_LSB;
   localparam int FRAME_LSB = 12;
   localparam int PFN_W     = 20;
   localparam int PA_W      = PFN_W + FRAME_LSB;
   localparam int SHIFT_W   = 5;
   localparam int SEG_W     = 3;

   typedef enum logic [2:0] {
      FLT_NONE      = 3'd0,
      FLT_ADDR_LD   = 3'd1,
      FLT_ADDR_ST   = 3'd2,
      FLT_REFILL_LD = 3'd3,
      FLT_REFILL_ST = 3'd4,
      FLT_INVAL_LD  = 3'd5,
      FLT_INVAL_ST  = 3'd6,
      FLT_MODIFIED  = 3'd7
   } fault_e;

   typedef struct packed {
      logic [PFN_W-1:0] pfn;
      logic             v;
      logic             d;
   } half_t;
endpackage

// File: rtl/tlbx_entry_array.sv
module tlbx_entry_array
   import tlbx_pkg::*;
#(
   parameter int N_ENTRIES = 16,
   parameter int ASID_W    = 8,
   localparam int IDX_W    = $clog2(N_ENTRIES)
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 wr_en,
   input  logic [IDX_W-1:0]                     wr_idx,
   input  logic [KEY_W-1:0]                     wr_key,
   input  logic [ASID_W-1:0]                    wr_asid,
   input  logic                                 wr_glb,
   input  logic [SHIFT_W-1:0]                   wr_shift,
   input  half_t                                wr_even,
   input  half_t                                wr_odd,
   input  logic [KEY_W-1:0]                     lk_key,
   input  logic [ASID_W-1:0]                    lk_asid,
   output logic [N_ENTRIES-1:0]                 match,
   output logic [N_ENTRIES-1:0][SHIFT_W-1:0]    ent_shift,
   output half_t [N_ENTRIES-1:0]                ent_even,
   output half_t [N_ENTRIES-1:0]                ent_odd
);
   localparam int DROP_BASE = KEY_LSB - 1;

   for (genvar e = 0; e < N_ENTRIES; e++) begin : g_ent
      logic [KEY_W-1:0]   key_q;
      logic [ASID_W-1:0]  asid_q;
      logic               glb_q;
      logic [SHIFT_W-1:0] sh_q;
      half_t              ev_q;
      half_t              od_q;
      logic               sel_w;
      logic [KEY_W-1:0]   cmp_mask;
      logic               live;
      logic               asid_ok;
      logic               key_ok;

      assign sel_w = wr_en && (wr_idx == IDX_W'(e));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            key_q  <= '0;
            asid_q <= '0;
            glb_q  <= 1'b0;
            sh_q   <= SHIFT_W'(FRAME_LSB);
            ev_q   <= '0;
            od_q   <= '0;
         end else if (sel_w) begin
            key_q  <= wr_key;
            asid_q <= wr_asid;
            glb_q  <= wr_glb;
            sh_q   <= wr_shift;
            ev_q   <= wr_even;
            od_q   <= wr_odd;
         end
      end

      always_comb begin
         cmp_mask = '1;
         for (int b = 0; b < KEY_W; b++) begin
            if (b < int'(sh_q) - DROP_BASE) cmp_mask[b] = 1'b0;
         end
      end

      assign live    = ev_q.v | od_q.v;
      assign asid_ok = glb_q | (asid_q == lk_asid);
      assign key_ok  = ((key_q ^ lk_key) & cmp_mask) == '0;

      assign match[e]     = live & asid_ok & key_ok;
      assign ent_shift[e] = sh_q;
      assign ent_even[e]  = ev_q;
      assign ent_odd[e]   = od_q;

      // R12: a write lands in the addressed entry on the next cycle
      a_r12_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_idx == IDX_W'(e)) |=> (key_q == $past(wr_key) && sh_q == $past(wr_shift)));
   end
endmodule

// File: rtl/tlbx_pick.sv
module tlbx_pick
   import tlbx_pkg::*;
#(
   parameter int N_ENTRIES = 16
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [VA_W-1:0]                    va,
   input  logic [N_ENTRIES-1:0]               match,
   input  logic [N_ENTRIES-1:0][SHIFT_W-1:0]  ent_shift,
   input  half_t [N_ENTRIES-1:0]              ent_even,
   input  half_t [N_ENTRIES-1:0]              ent_odd,
   output logic                               found,
   output half_t                              sel_half,
   output logic [SHIFT_W-1:0]                 sel_shift
);
   logic [N_ENTRIES-1:0] grant;
   half_t                win_even;
   half_t                win_odd;
   logic                 odd_pick;

   always_comb begin
      grant     = '0;
      found     = 1'b0;
      win_even  = '0;
      win_odd   = '0;
      sel_shift = SHIFT_W'(FRAME_LSB);
      for (int e = 0; e < N_ENTRIES; e++) begin
         if (match[e] && !found) begin
            found     = 1'b1;
            grant[e]  = 1'b1;
            win_even  = ent_even[e];
            win_odd   = ent_odd[e];
            sel_shift = ent_shift[e];
         end
      end
   end

   assign odd_pick = va[sel_shift];
   assign sel_half = odd_pick ? win_odd : win_even;

   // R6: at most one entry is granted and a grant exists whenever any entry matches
   a_r6_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && ((match != '0) == (grant != '0)));
endmodule

// File: rtl/tlbx_resolve.sv
module tlbx_resolve
   import tlbx_pkg::*;
#(
   parameter int SIZE_W = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [VA_W-1:0]     va,
   input  logic [SIZE_W-1:0]   size,
   input  logic                write,
   input  logic                kernel,
   input  logic                found,
   input  half_t               half,
   input  logic [SHIFT_W-1:0]  shift,
   output logic [2:0]          fault,
   output logic                hit,
   output logic [PA_W-1:0]     paddr
);
   localparam logic [SEG_W-1:0] SEG_LOW  = 3'b100;
   localparam logic [SEG_W-1:0] SEG_HIGH = 3'b101;

   logic [SEG_W-1:0] seg;
   logic             in_low;
   logic             in_high;
   logic             misal;
   logic [PA_W-1:0]  off_mask;
   logic [PA_W-1:0]  frame;
   logic [PA_W-1:0]  mapped_pa;
   logic [PA_W-1:0]  direct_pa;
   fault_e           code;

   assign seg     = va[VA_W-1 -: SEG_W];
   assign in_low  = (seg == SEG_LOW);
   assign in_high = (seg == SEG_HIGH);
   assign misal   = ((size - SIZE_W'(1)) & va[SIZE_W-1:0]) != '0;

   assign off_mask  = (PA_W'(1) << shift) - PA_W'(1);
   assign frame     = {half.pfn, {FRAME_LSB{1'b0}}};
   assign mapped_pa = (frame & ~off_mask) | (va & off_mask);
   assign direct_pa = {{SEG_W{1'b0}}, va[VA_W-SEG_W-1:0]};

   always_comb begin
      code = FLT_NONE;
      if (!req_valid)                 code = FLT_NONE;
      else if (misal || (in_low && !kernel))
                                      code = write ? FLT_ADDR_ST : FLT_ADDR_LD;
      else if (in_low || in_high)     code = FLT_NONE;
      else if (!found)                code = write ? FLT_REFILL_ST : FLT_REFILL_LD;
      else if (!half.v)               code = write ? FLT_INVAL_ST : FLT_INVAL_LD;
      else if (write && !half.d)      code = FLT_MODIFIED;
      else                            code = FLT_NONE;
   end

   assign fault = code;
   assign hit   = req_valid && (code == FLT_NONE);
   assign paddr = !hit ? '0 : ((in_low || in_high) ? direct_pa : mapped_pa);

   // R2: a misaligned request always reports the address error
   a_r2_misalign_traps: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && misal) |-> (fault == (write ? 3'd2 : 3'd1)));

   // R3: user mode cannot use the lower unmapped window
   a_r3_user_seg_low: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && in_low && !kernel) |-> (!hit && (fault == 3'd1 || fault == 3'd2)));

   // R4: the upper window always translates by stripping the top bits when aligned
   a_r4_upper_seg_paddr: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && in_high && !misal) |-> (hit && paddr[VA_W-SEG_W-1:0] == va[VA_W-SEG_W-1:0]
                                            && paddr[PA_W-1 -: SEG_W] == '0));

   // R10: the modified fault only follows a store
   a_r10_modify_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      (fault == 3'd7) |-> write);
endmodule

// File: rtl/tlbx_translator.sv
module tlbx_translator
   import tlbx_pkg::*;
#(
   parameter int N_ENTRIES = 16,
   parameter int ASID_W    = 8,
   parameter int SIZE_W    = 3,
   parameter int MIN_SHIFT = 11,
   parameter int MAX_SHIFT = 24,
   localparam int IDX_W    = $clog2(N_ENTRIES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic [31:0]          req_vaddr,
   input  logic [SIZE_W-1:0]    req_size,
   input  logic [ASID_W-1:0]    req_asid,
   input  logic                 req_write,
   input  logic                 req_kernel,
   input  logic                 req_small,
   input  logic                 wr_en,
   input  logic [IDX_W-1:0]     wr_idx,
   input  logic [20:0]          wr_vpn,
   input  logic [ASID_W-1:0]    wr_asid,
   input  logic                 wr_global,
   input  logic [4:0]           wr_shift,
   input  logic [19:0]          wr_pfn_even,
   input  logic                 wr_valid_even,
   input  logic                 wr_dirty_even,
   input  logic [19:0]          wr_pfn_odd,
   input  logic                 wr_valid_odd,
   input  logic                 wr_dirty_odd,
   output logic                 rsp_hit,
   output logic [31:0]          rsp_paddr,
   output logic [2:0]           rsp_fault,
   output logic [20:0]          rsp_vpn
);
   localparam int KEEP_LO = 2;

   if (N_ENTRIES < 2) begin : g_bad_depth
      $error("tlbx_translator: N_ENTRIES must be at least 2");
   end
   if (MIN_SHIFT < KEY_LSB || MAX_SHIFT > VA_W - 2 || MIN_SHIFT > MAX_SHIFT) begin : g_bad_shift
      $error("tlbx_translator: page shift bounds out of range");
   end
   if (SIZE_W < 1 || SIZE_W > KEY_LSB) begin : g_bad_size
      $error("tlbx_translator: SIZE_W out of range");
   end

   logic [KEY_W-1:0]                  key;
   logic [N_ENTRIES-1:0]              match;
   logic [N_ENTRIES-1:0][SHIFT_W-1:0] ent_shift;
   half_t [N_ENTRIES-1:0]             ent_even;
   half_t [N_ENTRIES-1:0]             ent_odd;
   logic                              found;
   half_t                             sel_half;
   logic [SHIFT_W-1:0]                sel_shift;
   half_t                             w_even;
   half_t                             w_odd;

   assign key = {req_vaddr[VA_W-1:KEY_LSB+KEEP_LO],
                 req_small ? req_vaddr[KEY_LSB+KEEP_LO-1:KEY_LSB] : {KEEP_LO{1'b0}}};
   assign rsp_vpn = key;

   assign w_even = '{pfn: wr_pfn_even, v: wr_valid_even, d: wr_dirty_even};
   assign w_odd  = '{pfn: wr_pfn_odd,  v: wr_valid_odd,  d: wr_dirty_odd};

   tlbx_entry_array #(.N_ENTRIES(N_ENTRIES), .ASID_W(ASID_W)) u_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_key   (wr_vpn),
      .wr_asid  (wr_asid),
      .wr_glb   (wr_global),
      .wr_shift (wr_shift),
      .wr_even  (w_even),
      .wr_odd   (w_odd),
      .lk_key   (key),
      .lk_asid  (req_asid),
      .match    (match),
      .ent_shift(ent_shift),
      .ent_even (ent_even),
      .ent_odd  (ent_odd)
   );

   tlbx_pick #(.N_ENTRIES(N_ENTRIES)) u_pick (
      .clk      (clk),
      .rst_n    (rst_n),
      .va       (req_vaddr),
      .match    (match),
      .ent_shift(ent_shift),
      .ent_even (ent_even),
      .ent_odd  (ent_odd),
      .found    (found),
      .sel_half (sel_half),
      .sel_shift(sel_shift)
   );

   tlbx_resolve #(.SIZE_W(SIZE_W)) u_resolve (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_valid(req_valid),
      .va       (req_vaddr),
      .size     (req_size),
      .write    (req_write),
      .kernel   (req_kernel),
      .found    (found),
      .half     (sel_half),
      .shift    (sel_shift),
      .fault    (rsp_fault),
      .hit      (rsp_hit),
      .paddr    (rsp_paddr)
   );

   // R13: an idle request port produces no hit, no fault and a zero address
   a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> (!rsp_hit && rsp_fault == 3'd0 && rsp_paddr == '0));

   // R13: a hit never carries a fault code
   a_r13_hit_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> (rsp_fault == 3'd0));

   // R11: software only loads page shifts within the supported range
   a_r11_shift_legal: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (int'(wr_shift) >= MIN_SHIFT && int'(wr_shift) <= MAX_SHIFT));
endmodule

// File: tb/tlbx_translator_test.sv
module tlbx_translator_test;
   localparam int CLK_P = 10;
   localparam int NE    = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic [2:0]  req_size = 3'd1;
   logic [7:0]  req_asid = '0;
   logic        req_write = 1'b0, req_kernel = 1'b0, req_small = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_idx = '0;
   logic [20:0] wr_vpn = '0;
   logic [7:0]  wr_asid = '0;
   logic        wr_global = 1'b0;
   logic [4:0]  wr_shift = 5'd12;
   logic [19:0] wr_pfn_even = '0, wr_pfn_odd = '0;
   logic        wr_valid_even = 1'b0, wr_dirty_even = 1'b0, wr_valid_odd = 1'b0, wr_dirty_odd = 1'b0;
   logic        rsp_hit;
   logic [31:0] rsp_paddr;
   logic [2:0]  rsp_fault;
   logic [20:0] rsp_vpn;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   logic [20:0] m_key  [NE];
   logic [7:0]  m_asid [NE];
   logic        m_glb  [NE];
   logic [4:0]  m_sh   [NE];
   logic [19:0] m_p0   [NE];
   logic [19:0] m_p1   [NE];
   logic        m_v0 [NE], m_d0 [NE], m_v1 [NE], m_d1 [NE];

   always #(CLK_P/2) clk = ~clk;

   tlbx_translator uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
      .req_size(req_size), .req_asid(req_asid), .req_write(req_write),
      .req_kernel(req_kernel), .req_small(req_small), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_vpn(wr_vpn), .wr_asid(wr_asid), .wr_global(wr_global), .wr_shift(wr_shift),
      .wr_pfn_even(wr_pfn_even), .wr_valid_even(wr_valid_even), .wr_dirty_even(wr_dirty_even),
      .wr_pfn_odd(wr_pfn_odd), .wr_valid_odd(wr_valid_odd), .wr_dirty_odd(wr_dirty_odd),
      .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_vpn(rsp_vpn)
   );

   function automatic void predict(input logic [31:0] va, input logic [2:0] sz,
                                   input logic [7:0] asid, input logic wr, input logic kern,
                                   input logic sml, output logic [2:0] f, output logic h,
                                   output logic [31:0] pa, output logic [20:0] key);
      logic mis, s0, s1, found, odd, v, d;
      logic [19:0] pfn;
      logic [31:0] om;
      int he;
      key = va[31:11];
      if (!sml) key[1:0] = 2'b00;
      mis = (va[2:0] & (sz - 3'd1)) != 3'd0;
      s0  = (va[31:29] == 3'b100);
      s1  = (va[31:29] == 3'b101);
      found = 1'b0;
      he = 0;
      for (int e = 0; e < NE; e++) begin
         if (!found && (m_v0[e] || m_v1[e]) && (m_glb[e] || m_asid[e] == asid)
             && ((key >> (int'(m_sh[e]) - 10)) == (m_key[e] >> (int'(m_sh[e]) - 10)))) begin
            found = 1'b1;
            he = e;
         end
      end
      f = 3'd0;
      pa = '0;
      odd = va[m_sh[he]];
      v   = odd ? m_v1[he] : m_v0[he];
      d   = odd ? m_d1[he] : m_d0[he];
      pfn = odd ? m_p1[he] : m_p0[he];
      if (mis || (s0 && !kern)) f = wr ? 3'd2 : 3'd1;
      else if (s0 || s1)        f = 3'd0;
      else if (!found)          f = wr ? 3'd4 : 3'd3;
      else if (!v)              f = wr ? 3'd6 : 3'd5;
      else if (wr && !d)        f = 3'd7;
      h = (f == 3'd0);
      if (h) begin
         if (s0 || s1) pa = {3'b000, va[28:0]};
         else begin
            om = (32'd1 << m_sh[he]) - 32'd1;
            pa = ({pfn, 12'h000} & ~om) | (va & om);
         end
      end
   endfunction

   task automatic put_entry(input int idx, input logic [20:0] k, input logic [7:0] a,
                            input logic g, input logic [4:0] sh,
                            input logic [19:0] p0, input logic v0, input logic d0,
                            input logic [19:0] p1, input logic v1, input logic d1);
      req_valid = 1'b0;
      wr_en = 1'b1; wr_idx = idx[3:0]; wr_vpn = k; wr_asid = a; wr_global = g; wr_shift = sh;
      wr_pfn_even = p0; wr_valid_even = v0; wr_dirty_even = d0;
      wr_pfn_odd = p1; wr_valid_odd = v1; wr_dirty_odd = d1;
      @(posedge clk);
      m_key[idx] = k; m_asid[idx] = a; m_glb[idx] = g; m_sh[idx] = sh;
      m_p0[idx] = p0; m_v0[idx] = v0; m_d0[idx] = d0;
      m_p1[idx] = p1; m_v1[idx] = v1; m_d1[idx] = d1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic probe(input logic [31:0] va, input logic [2:0] sz, input logic [7:0] asid,
                        input logic wr, input logic kern, input logic sml, input string tag);
      logic [2:0] ef;
      logic eh;
      logic [31:0] ep;
      logic [20:0] ek;
      req_valid = 1'b1; req_vaddr = va; req_size = sz; req_asid = asid;
      req_write = wr; req_kernel = kern; req_small = sml;
      predict(va, sz, asid, wr, kern, sml, ef, eh, ep, ek);
      #(CLK_P/4);
      checks++;
      if (rsp_fault !== ef || rsp_hit !== eh || rsp_paddr !== ep || rsp_vpn !== ek) begin
         failures++;
         $display("FAIL %s va=%h: actual fault=%0d hit=%0b pa=%h vpn=%h expected fault=%0d hit=%0b pa=%h vpn=%h",
                  tag, va, rsp_fault, rsp_hit, rsp_paddr, rsp_vpn, ef, eh, ep, ek);
      end
      @(negedge clk);
   endtask

   task automatic idle_check(input string tag);
      req_valid = 1'b0;
      req_vaddr = 32'h9000_0001;
      #(CLK_P/4);
      checks++;
      if (rsp_hit !== 1'b0 || rsp_fault !== 3'd0 || rsp_paddr !== 32'd0) begin
         failures++;
         $display("FAIL %s: actual hit=%0b fault=%0d pa=%h expected hit=0 fault=0 pa=0",
                  tag, rsp_hit, rsp_fault, rsp_paddr);
      end
      @(negedge clk);
   endtask

   initial begin
      #(CLK_P * 190000);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog: actual run still busy expected finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int e = 0; e < NE; e++) begin
         m_key[e] = '0; m_asid[e] = '0; m_glb[e] = 1'b0; m_sh[e] = 5'd12;
         m_p0[e] = '0; m_p1[e] = '0; m_v0[e] = 1'b0; m_d0[e] = 1'b0; m_v1[e] = 1'b0; m_d1[e] = 1'b0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: empty table after reset
      probe(32'h0000_1000, 3'd4, 8'd0, 1'b0, 1'b1, 1'b0, "R1 reset refill load");
      probe(32'h0000_0000, 3'd1, 8'd0, 1'b1, 1'b1, 1'b0, "R1 reset refill store");
      // R13: idle port
      idle_check("R13 idle quiet");
      // R3: lower unmapped window
      probe(32'h8123_4568, 3'd4, 8'd3, 1'b0, 1'b1, 1'b0, "R3 kernel low window");
      probe(32'h8123_4568, 3'd4, 8'd3, 1'b0, 1'b0, 1'b0, "R3 user low window load");
      probe(32'h8123_4568, 3'd2, 8'd3, 1'b1, 1'b0, 1'b0, "R3 user low window store");
      // R4: upper unmapped window
      probe(32'hA000_0010, 3'd4, 8'd3, 1'b0, 1'b0, 1'b0, "R4 user upper window");
      probe(32'hBFFF_FFFE, 3'd2, 8'd3, 1'b1, 1'b1, 1'b0, "R4 kernel upper window");
      // R2: misalignment outranks all
      probe(32'h0000_1001, 3'd2, 8'd0, 1'b0, 1'b1, 1'b0, "R2 misaligned load over refill");
      probe(32'hA000_0006, 3'd4, 8'd0, 1'b1, 1'b1, 1'b0, "R2 misaligned store upper window");

      // R11 R9 R10 R12: a 4 KiB pair
      put_entry(0, 21'h000800, 8'd5, 1'b0, 5'd12, 20'h12345, 1'b1, 1'b1, 20'h54321, 1'b1, 1'b0);
      probe(32'h0040_0ABC, 3'd4, 8'd5, 1'b0, 1'b0, 1'b0, "R12 R11 even page next cycle");
      probe(32'h0040_1ABC, 3'd4, 8'd5, 1'b0, 1'b0, 1'b0, "R9 odd page load");
      probe(32'h0040_1ABC, 3'd4, 8'd5, 1'b1, 1'b0, 1'b0, "R10 clean odd store");
      probe(32'h0040_0ABC, 3'd4, 8'd5, 1'b1, 1'b0, 1'b0, "R10 dirty even store");
      probe(32'h0040_0ABC, 3'd4, 8'd6, 1'b0, 1'b0, 1'b0, "R6 R8 asid mismatch load");
      probe(32'h0040_0ABC, 3'd4, 8'd6, 1'b1, 1'b0, 1'b0, "R8 asid mismatch store");
      // R9: invalid half
      put_entry(1, 21'h001000, 8'd5, 1'b0, 5'd12, 20'h0AAAA, 1'b0, 1'b1, 20'h0BBBB, 1'b1, 1'b1);
      probe(32'h0080_0010, 3'd4, 8'd5, 1'b0, 1'b0, 1'b0, "R9 invalid even load");
      probe(32'h0080_0010, 3'd4, 8'd5, 1'b1, 1'b0, 1'b0, "R9 invalid even store");
      probe(32'h0080_1010, 3'd4, 8'd5, 1'b1, 1'b0, 1'b0, "R9 valid odd store");
      // R7: global entry
      put_entry(2, 21'h001800, 8'd9, 1'b1, 5'd12, 20'h00C0C, 1'b1, 1'b1, 20'h00D0D, 1'b1, 1'b1);
      probe(32'h00C0_0444, 3'd4, 8'd77, 1'b0, 1'b0, 1'b0, "R7 global any asid");
      // R5: small-page key
      put_entry(3, 21'h002002, 8'd1, 1'b0, 5'd11, 20'h0F00F, 1'b1, 1'b1, 20'h0E00E, 1'b1, 1'b1);
      probe(32'h0100_1234, 3'd4, 8'd1, 1'b0, 1'b0, 1'b1, "R5 small mode keeps low key bits");
      probe(32'h0100_1934, 3'd4, 8'd1, 1'b0, 1'b0, 1'b1, "R5 small mode odd 2K page");
      probe(32'h0100_1234, 3'd4, 8'd1, 1'b0, 1'b0, 1'b0, "R5 normal mode clears low key bits");
      // R6 R12: duplicates, lowest index, then removal
      put_entry(5, 21'h003000, 8'd2, 1'b0, 5'd12, 20'h55555, 1'b1, 1'b1, 20'h55556, 1'b1, 1'b1);
      put_entry(4, 21'h003000, 8'd2, 1'b0, 5'd12, 20'h44444, 1'b1, 1'b1, 20'h44445, 1'b1, 1'b1);
      probe(32'h0180_0008, 3'd4, 8'd2, 1'b0, 1'b0, 1'b0, "R6 lowest index wins");
      put_entry(4, 21'h003000, 8'd2, 1'b0, 5'd12, 20'h44444, 1'b0, 1'b1, 20'h44445, 1'b0, 1'b1);
      probe(32'h0180_0008, 3'd4, 8'd2, 1'b0, 1'b0, 1'b0, "R12 R6 removed entry yields next");
      // R11: 16 KiB pages
      put_entry(6, 21'h004000, 8'd3, 1'b0, 5'd14, 20'h12340, 1'b1, 1'b1, 20'h56780, 1'b1, 1'b1);
      probe(32'h0200_6123, 3'd1, 8'd3, 1'b0, 1'b0, 1'b0, "R11 16K odd page");
      probe(32'h0200_2123, 3'd1, 8'd3, 1'b0, 1'b0, 1'b1, "R11 16K even page small mode");

      // random mix
      for (int it = 0; it < 800; it++) begin
         int sel;
         int ei;
         logic [31:0] va;
         logic [31:0] pm;
         logic [7:0]  as;
         sel = int'($urandom % 10);
         ei  = int'($urandom % NE);
         if (sel == 0) begin
            put_entry(ei, {1'b0, 20'($urandom)}, 8'($urandom % 4), ($urandom % 5) == 0,
                      5'(11 + $urandom % 6), 20'($urandom), 1'($urandom), 1'($urandom),
                      20'($urandom), 1'($urandom), 1'($urandom));
         end else begin
            if (sel < 7) begin
               pm = (32'd1 << (int'(m_sh[ei]) + 1)) - 32'd1;
               va = ({m_key[ei], 11'h000} & ~pm) | ($urandom & pm);
               as = (($urandom % 4) == 0) ? 8'($urandom % 4) : m_asid[ei];
            end else if (sel == 7) begin
               va = {2'b10, 30'($urandom)};
               as = 8'($urandom);
            end else begin
               va = $urandom;
               as = 8'($urandom % 4);
            end
            probe(va, 3'd1 << ($urandom % 3), as, 1'($urandom), 1'($urandom), 1'($urandom),
                  "R6 R8 R9 R10 R11 random");
         end
      end
      idle_check("R13 idle after random");

      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule